// File: doc/BRIEF.md
# Serial Peripheral Master Frame Sequencer

This block is a serial peripheral master that moves one word per frame in each direction. Words of 4 to 16 bits go out most significant bit first on the transmit line and come back the same way on the receive line. The serial clock idles low. Data is launched on rising edges and sampled on falling edges. An active-low frame select wraps each transfer.

On the parallel side, words enter through a valid/ready port into an 8-entry FIFO. Received words leave as a one-cycle strobe with the data right-aligned.

A frame opens when the block is enabled and the FIFO holds a word. Frame select stays low while more words are queued. It closes one full serial period after the last sample. Word size and the half-period divider are captured when a frame opens.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, and whenever no frame is open, sclk_o=0, cs_n_o=1, mosi_o=0 and busy_o=0.
- R2: A frame opens on a clock edge where en_i=1 and the FIFO holds at least one word: cs_n_o goes low after that edge and that word is taken. No frame opens while en_i=0.
- R3: The first rising edge of sclk_o, carrying the word's most significant bit on mosi_o, comes H=(div_i+1) system cycles after cs_n_o falls.
- R4: sclk_o alternates with half-period H. mosi_o changes only together with a rising edge of sclk_o. miso_i is sampled at each falling edge. Bits go most significant first.
- R5: The word length n is size_i, limited to the range 4..16 (size_i<4 gives 4, size_i>16 gives 16). Bit n-1 of tx_data_i is sent first, and bits above n-1 are ignored.
- R6: After the clock edge that makes the last falling sclk_o edge of a word, rx_valid_o is 1 for exactly one cycle. rx_data_o holds the n sampled bits, right-aligned, with zeros above bit n-1.
- R7: If the FIFO is empty at the last falling edge, cs_n_o rises 2H cycles after that edge, and mosi_o returns to 0 at the same time.
- R8: If the FIFO holds a word at the last falling edge, that word is taken. cs_n_o stays low, and the new word's first rising edge comes H cycles later.
- R9: The transmit FIFO holds 8 words. tx_ready_o=0 exactly while it holds 8. A word is accepted on an edge with tx_valid_i=1 and tx_ready_o=1.
- R10: div_i and size_i are captured when a frame opens and hold for the whole frame, including back-to-back words. Changes during a frame have no effect on it.
- R11: busy_o is high exactly while cs_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Permits a new frame to open |
| size_i | input | 5 | Word length in bits, clamped to 4..16 |
| div_i | input | 8 | Half-period is div_i+1 system cycles |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_data_i | input | 16 | Transmit word, right-aligned |
| tx_ready_o | output | 1 | FIFO can accept a word |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| rx_data_o | output | 16 | Received word, right-aligned, zero-extended |
| busy_o | output | 1 | Frame in progress |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial transmit line |
| miso_i | input | 1 | Serial receive line |

## Verification
The bench builds the block with its defaults: 16-bit words, an 8-entry FIFO and an 8-bit divider. With these, word lengths from the clamped minimum up to the full 16 bits are reachable, and so is a completely full FIFO, which drives tx_ready_o low and feeds an eight-word back-to-back burst. Small divider values (0 to 3) keep every frame short. They still exercise the one-cycle half-period, where rising and falling edges come on consecutive cycles and the valid strobe must stay a single pulse. A random receive stream and changes to size and divider in the middle of a frame show that the captured settings alone govern each frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int unsigned MIN_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a full FIFO refuses further words
  a_r9_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> full_o && $stable(wr_ptr));
endmodule

// File: rtl/spi_seq_halfclk.sv
module spi_seq_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = run_i && (cnt == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (!run_i || tick_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R4: half-period count never runs past the captured divider
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) |-> cnt <= div_i);
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int W      = 16,
  parameter int DIV_W  = 8,
  parameter int SIZE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              fifo_empty_i,
  input  logic [W-1:0]      fifo_data_i,
  output logic              pop_o,
  input  logic              tick_i,
  output logic              run_o,
  output logic [DIV_W-1:0]  div_q_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              rx_valid_o,
  output logic [W-1:0]      rx_data_o
);
  seq_state_e        state;
  logic [W-1:0]      tx_sr, rx_sr;
  logic [SIZE_W-1:0] n_q, bit_cnt, size_eff;
  logic              tail_half, last_bit, start, cont;

  always_comb begin
    if (size_i < SIZE_W'(MIN_BITS)) size_eff = SIZE_W'(MIN_BITS);
    else if (size_i > SIZE_W'(W))   size_eff = SIZE_W'(W);
    else                            size_eff = size_i;
  end

  assign last_bit = (bit_cnt == n_q - 1'b1);
  assign start    = (state == ST_IDLE) && en_i && !fifo_empty_i;
  assign cont     = (state == ST_RUN) && tick_i && sclk_o && last_bit && !fifo_empty_i;
  assign pop_o    = start || cont;
  assign run_o    = (state != ST_IDLE);
  assign busy_o   = run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cs_n_o     <= 1'b1;
      sclk_o     <= 1'b0;
      mosi_o     <= 1'b0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      bit_cnt    <= '0;
      n_q        <= SIZE_W'(MIN_BITS);
      div_q_o    <= '0;
      tail_half  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cs_n_o  <= 1'b0;
          n_q     <= size_eff;
          div_q_o <= div_i;
          tx_sr   <= fifo_data_i << (SIZE_W'(W) - size_eff);
          rx_sr   <= '0;
          bit_cnt <= '0;
          state   <= ST_LEAD;
        end
        ST_LEAD: if (tick_i) begin
          sclk_o <= 1'b1;
          mosi_o <= tx_sr[W-1];
          tx_sr  <= tx_sr << 1;
          state  <= ST_RUN;
        end
        ST_RUN: if (tick_i) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;
            if (last_bit) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= {rx_sr[W-2:0], miso_i};
              rx_sr      <= '0;
              bit_cnt    <= '0;
              if (!fifo_empty_i) tx_sr <= fifo_data_i << (SIZE_W'(W) - n_q);
              else begin
                tail_half <= 1'b0;
                state     <= ST_TAIL;
              end
            end else begin
              rx_sr   <= {rx_sr[W-2:0], miso_i};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else begin
            sclk_o <= 1'b1;
            mosi_o <= tx_sr[W-1];
            tx_sr  <= tx_sr << 1;
          end
        end
        ST_TAIL: if (tick_i) begin
          if (tail_half) begin
            cs_n_o <= 1'b1;
            mosi_o <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            tail_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> cs_n_o && !sclk_o && !mosi_o);
  a_r3_sclk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);
  a_r4_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r11_busy_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o != cs_n_o);
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master #(
  parameter int  DATA_W     = 16,
  parameter int  FIFO_DEPTH = 8,
  parameter int  DIV_W      = 8,
  localparam int SIZE_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic              fifo_empty, fifo_full, pop, tick, run;
  logic [DATA_W-1:0] fifo_data;
  logic [DIV_W-1:0]  div_q;

  assign tx_ready_o = !fifo_full;

  spi_seq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .data_i  (tx_data_i),
    .pop_i   (pop),
    .data_o  (fifo_data),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  spi_seq_halfclk #(.DIV_W(DIV_W)) u_halfclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_seq_engine #(.W(DATA_W), .DIV_W(DIV_W), .SIZE_W(SIZE_W)) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .size_i       (size_i),
    .div_i        (div_i),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .pop_o        (pop),
    .tick_i       (tick),
    .run_o        (run),
    .div_q_o      (div_q),
    .miso_i       (miso_i),
    .sclk_o       (sclk_o),
    .cs_n_o       (cs_n_o),
    .mosi_o       (mosi_o),
    .busy_o       (busy_o),
    .rx_valid_o   (rx_valid_o),
    .rx_data_o    (rx_data_o)
  );

  // R2: no frame may open while disabled
  a_r2_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o && !en_i |=> cs_n_o);
endmodule

// File: tb/sim_spi_seq_master.sv
module sim_spi_seq_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  size = 5'd8;
  logic [7:0]  div = 8'd0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        miso = 1'b0;
  logic        tx_ready, rx_valid, busy, sclk, cs_n, mosi;
  logic [15:0] rx_data;

  int checks = 0, fails = 0, cycles = 0, pushed = 0;

  always #2.5 clk = ~clk;

  spi_seq_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .size_i(size), .div_i(div),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .busy_o(busy),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // behavioural reference: timeline per word, k edges since word base
  int unsigned q[$];
  int  m_state = 0, k = 0, hp = 1, nb = 4, rx_cnt = 0;
  int unsigned word = 0, acc = 0;
  bit  m_sclk = 0, m_cs = 1, m_mosi = 0, m_rxv = 0;
  int unsigned m_rxd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_state = 0; k = 0; m_sclk = 0; m_cs = 1; m_mosi = 0;
      m_rxv = 0; m_rxd = 0;
    end else begin
      bit push_now;
      push_now = tx_valid && (q.size() < 8);
      m_rxv = 0;
      if (m_state == 0) begin
        if (en && q.size() > 0) begin
          word = q.pop_front();
          hp = int'(div) + 1;
          nb = (size < 4) ? 4 : (size > 16) ? 16 : int'(size);
          m_cs = 0; k = 0; acc = 0; m_state = 1;
        end
      end else if (m_state == 1) begin
        k++;
        if (k >= hp && (k - hp) % (2 * hp) == 0 && k < 2 * hp * nb) begin
          m_sclk = 1;
          m_mosi = word[nb - 1 - (k - hp) / (2 * hp)];
        end else if (k >= 2 * hp && (k - 2 * hp) % (2 * hp) == 0 && k <= 2 * hp * nb) begin
          m_sclk = 0;
          acc = (acc << 1) | miso;
          if (k == 2 * hp * nb) begin
            m_rxv = 1; m_rxd = acc; acc = 0; rx_cnt++;
            k = 0;
            if (q.size() > 0) word = q.pop_front();
            else m_state = 2;
          end
        end
      end else begin
        k++;
        if (k == 2 * hp) begin
          m_cs = 1; m_mosi = 0; m_state = 0;
        end
      end
      if (push_now) q.push_back(tx_data);
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp,
                     input string sig, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h at cycle %0d", req, sig, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(16'(sclk), 16'(m_sclk), "sclk_o", "R3,R4");
      chk(16'(cs_n), 16'(m_cs), "cs_n_o", "R2,R7,R8,R10");
      chk(16'(mosi), 16'(m_mosi), "mosi_o", "R4,R5");
      chk(16'(busy), 16'(!m_cs), "busy_o", "R11");
      chk(16'(tx_ready), 16'(q.size() < 8), "tx_ready_o", "R9");
      chk(16'(rx_valid), 16'(m_rxv), "rx_valid_o", "R6");
      if (m_rxv) chk(rx_data, 16'(m_rxd), "rx_data_o", "R6,R5");
      miso <= 1'($urandom);
    end
  end

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = w; pushed++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic settle();
    int t = 0;
    @(negedge clk);
    while ((m_state != 0 || q.size() != 0) && t < 40000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic one(input logic [4:0] s, input logic [7:0] d, input logic [15:0] w);
    size = s; div = d; en = 1'b1;
    push(w);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk(16'({sclk, cs_n, mosi, busy}), 16'b0100, "idle lines", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(16'(tx_ready), 16'd1, "tx_ready_o after reset", "R1");

    // R2: disabled, a queued word must not open a frame
    push(16'h00A5);
    repeat (40) @(negedge clk);
    chk(16'(cs_n), 16'd1, "cs_n_o while disabled", "R2");
    size = 5'd8; div = 8'd2; en = 1'b1;
    settle();

    one(5'd4, 8'd0, 16'hFFF9);   // R5 minimum size, one-cycle half period
    one(5'd16, 8'd1, 16'hC3A5);  // R5 full width
    one(5'd2, 8'd0, 16'h000D);   // R5 clamp low -> 4
    one(5'd20, 8'd3, 16'h8001);  // R5 clamp high -> 16
    one(5'd7, 8'd3, 16'h0055);

    // R8: back-to-back burst
    en = 1'b0; size = 5'd6; div = 8'd1;
    push(16'h002A); push(16'h0015); push(16'h003F);
    en = 1'b1;
    settle();

    // R9: fill the FIFO, then R10: change settings inside the burst
    en = 1'b0; size = 5'd9; div = 8'd0;
    for (int i = 0; i < 8; i++) push(16'(i * 16'h0123 + 16'h0041));
    @(negedge clk);
    chk(16'(tx_ready), 16'd0, "tx_ready_o with 8 queued", "R9");
    en = 1'b1;
    repeat (5) @(negedge clk);
    size = 5'd13; div = 8'd3;
    repeat (20) @(negedge clk);
    en = 1'b0;
    settle();

    // R8: words streamed in while a frame is running
    size = 5'd5; div = 8'd2; en = 1'b1;
    for (int i = 0; i < 4; i++) push(16'(16'h0011 * i));
    settle();

    chk(16'(rx_cnt), 16'(pushed), "received word count", "R6,R8");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d expected end before 150000", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule